// File: doc/BRIEF.md
# Ethernet Destination-Address Hash Filter

This block decides whether the destination address of a received Ethernet frame falls on an enabled entry of a programmable hash table. The six address bytes arrive one per accepted cycle, and the first byte is marked with a start strobe. A CRC-32 is folded over the bytes, and the top bits of the CRC register form a table index. That index selects one bit in a set of sixteen 32-bit table words. The words form two banks of eight, an individual bank and a group bank, and software writes and reads them through a plain register port.

A mode input chooses the table layout. With the mode low, there are two separate 256-entry tables indexed by 8 CRC bits. Unicast frames use the individual bank and multicast frames use the group bank. With the mode high, both banks together form one 512-entry multicast table indexed by 9 CRC bits, and unicast frames never hit. A hit only means that the address belongs to the set of addresses mapped to an enabled entry. Any further address screening belongs to the consumer of the result.

Top module: `da_hash_filter`

## Requirements
- R1: After reset, all sixteen table words read as zero and `match_valid` and `match_hit` are low.
- R2: When `reg_wr` is high at a clock edge, `reg_wdata` is stored into the word selected by `reg_addr`. `reg_rdata` shows the selected word combinationally. Addresses 0–7 select individual-bank words 0–7, and addresses 8–15 select group-bank words 0–7.
- R3: The CRC register is preset to all ones when a byte with `byte_first` is accepted. Each byte is consumed LSB first. For each bit, the feedback is the register MSB XOR the data bit, the register shifts left, and 0x04C11DB7 is XORed in when the feedback is 1. No final inversion is applied before the index bits are taken.
- R4: If the sixth address byte is accepted at edge E, then `match_valid` is high for exactly the one cycle that follows edge E+1, and `match_hit` and `match_index` are valid in that cycle.
- R5: With `ext_mode` low at edge E+1, the index is {0, CRC[31:24]}. A frame whose first byte has bit 0 set (multicast) is looked up in the group bank, and any other frame is looked up in the individual bank.
- R6: With `ext_mode` high, the index is CRC[31:23]. For a multicast frame, an index below 256 selects individual-bank word index[7:5], and an index of 256 or more selects group-bank word index[7:5].
- R7: With `ext_mode` high, a unicast frame (first byte bit 0 clear) always gives `match_hit` low, whatever the table holds, while its index is still reported.
- R8: Within the selected word, the entry number e = index[4:0] tests word bit 31−e.
- R9: A byte accepted with `byte_first` high discards any partly received address, and counting restarts from that byte.
- R10: Bytes with `byte_valid` high and `byte_first` low are ignored when no address is in progress, either after reset or after a sixth byte. No result pulse follows them.
- R11: The lookup at edge E+1 uses the table contents from before any register write at that same edge, and that write still lands.
- R12: `match_hit` is low whenever `match_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0: split 256-entry tables; 1: merged 512-entry multicast table |
| byte_valid | input | 1 | Address byte present this cycle |
| byte_first | input | 1 | Marks the first address byte; restarts the CRC |
| byte_data | input | 8 | Address byte, first byte first |
| reg_wr | input | 1 | Table word write enable |
| reg_addr | input | 4 | Table word address for write and read |
| reg_wdata | input | 32 | Table write data |
| reg_rdata | output | 32 | Table word at `reg_addr` |
| match_valid | output | 1 | One-cycle result strobe |
| match_hit | output | 1 | Indexed entry is enabled |
| match_index | output | 9 | Computed table index |

## Verification
A table write and a lookup can fall on the same clock edge, the edge that follows the sixth accepted byte. The bench provokes this by raising `reg_wr` in that exact cycle, once to set the frame's own entry bit and once to clear it. It judges the case by expecting the hit to reflect the old contents. It then expects the word to read back with the new value, and a repeat lookup of the same address to reflect the new value. A second overlap comes from a start strobe that cuts into a partial address. Here the bench expects exactly one result pulse, and that pulse carries the later address's index.

// File: rtl/dahf_pkg.sv
package dahf_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_BYTES  = 6;
    localparam int CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

    localparam int WORD_W      = 32;
    localparam int BANK_REGS   = 8;
    localparam int NUM_REGS    = 2 * BANK_REGS;
    localparam int REG_AW      = $clog2(NUM_REGS);
    localparam int REG_SEL_W   = $clog2(BANK_REGS);
    localparam int BIT_SEL_W   = $clog2(WORD_W);
    localparam int SPLIT_IDX_W = REG_SEL_W + BIT_SEL_W;
    localparam int EXT_IDX_W   = SPLIT_IDX_W + 1;

    typedef enum logic {
        BANK_IND = 1'b0,
        BANK_GRP = 1'b1
    } bank_e;

    typedef struct packed {
        bank_e                 bank;
        logic [REG_SEL_W-1:0]  reg_sel;
        logic [BIT_SEL_W-1:0]  bit_pos;
        logic                  enable;
    } dahf_slot_t;

    typedef struct packed {
        logic                  hit;
        logic [EXT_IDX_W-1:0]  index;
    } dahf_result_t;

    // One byte through the CRC shift register, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/dahf_crc_engine.sv
module dahf_crc_engine
    import dahf_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    parameter int IDX_W  = EXT_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic              byte_first,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [IDX_W-1:0]  crc_top,
    output logic              group_q,
    output logic              done_q
);
    localparam int CNT_W = $clog2(NBYTES + 1);

    logic [CRC_W-1:0] crc_q;
    logic [CNT_W-1:0] cnt_q;      // 0: idle, otherwise bytes taken so far
    logic [CRC_W-1:0] crc_base;
    logic [CNT_W-1:0] cnt_base;
    logic             take;
    logic             last;

    always_comb begin
        take     = byte_valid && (byte_first || (cnt_q != '0));
        crc_base = byte_first ? '1 : crc_q;
        cnt_base = byte_first ? '0 : cnt_q;
        last     = take && (cnt_base == CNT_W'(NBYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q   <= '1;
            cnt_q   <= '0;
            group_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (take) begin
                crc_q <= crc_step_byte(crc_base, byte_data);
                cnt_q <= last ? '0 : cnt_base + 1'b1;
            end
            if (byte_valid && byte_first) begin
                group_q <= byte_data[0];
            end
        end
    end

    assign crc_top = crc_q[CRC_W-1 -: IDX_W];

endmodule

// File: rtl/dahf_table_regs.sv
module dahf_table_regs
    import dahf_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int W     = WORD_W,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [W-1:0]       wdata,
    output logic [W-1:0]       rdata,
    output logic [NREGS*W-1:0] flat
);
    for (genvar g = 0; g < NREGS; g++) begin : g_word
        logic [W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && (addr == AW'(g))) begin
                word_q <= wdata;
            end
        end
        assign flat[g*W +: W] = word_q;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (addr == AW'(k)) begin
                rdata = flat[k*W +: W];
            end
        end
    end

endmodule

// File: rtl/dahf_lookup.sv
module dahf_lookup
    import dahf_pkg::*;
(
    input  logic [EXT_IDX_W-1:0]       crc_top,
    input  logic                       frame_group,
    input  logic                       ext_mode,
    input  logic [NUM_REGS*WORD_W-1:0] table_flat,
    output dahf_result_t               result
);
    logic [EXT_IDX_W-1:0] idx;
    dahf_slot_t           slot;
    logic [REG_AW-1:0]    word_sel;
    logic [WORD_W-1:0]    word;

    always_comb begin
        slot = '0;
        if (ext_mode) begin
            idx         = crc_top;
            slot.bank   = bank_e'(crc_top[EXT_IDX_W-1]);
            slot.enable = frame_group;
        end else begin
            idx         = {1'b0, crc_top[EXT_IDX_W-1:1]};
            slot.bank   = frame_group ? BANK_GRP : BANK_IND;
            slot.enable = 1'b1;
        end
        slot.reg_sel = idx[SPLIT_IDX_W-1 -: REG_SEL_W];
        slot.bit_pos = idx[BIT_SEL_W-1:0];
        word_sel     = {slot.bank, slot.reg_sel};
        word         = table_flat[int'(word_sel)*WORD_W +: WORD_W];
        result.hit   = slot.enable && word[BIT_SEL_W'(WORD_W - 1) - slot.bit_pos];
        result.index = idx;
    end

endmodule

// File: rtl/da_hash_filter.sv
module da_hash_filter
    import dahf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ext_mode,
    input  logic                 byte_valid,
    input  logic                 byte_first,
    input  logic [BYTE_W-1:0]    byte_data,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 match_valid,
    output logic                 match_hit,
    output logic [EXT_IDX_W-1:0] match_index
);
    logic [EXT_IDX_W-1:0]       crc_top;
    logic                       crc_group;
    logic                       crc_done;
    logic [NUM_REGS*WORD_W-1:0] table_flat;
    dahf_result_t               look_res;
    dahf_result_t               res_q;
    logic                       valid_q;

    dahf_crc_engine #(
        .NBYTES (ADDR_BYTES),
        .IDX_W  (EXT_IDX_W)
    ) u_crc (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_first (byte_first),
        .byte_data  (byte_data),
        .crc_top    (crc_top),
        .group_q    (crc_group),
        .done_q     (crc_done)
    );

    dahf_table_regs #(
        .NREGS (NUM_REGS),
        .W     (WORD_W),
        .AW    (REG_AW)
    ) u_table (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .flat  (table_flat)
    );

    dahf_lookup u_lookup (
        .crc_top     (crc_top),
        .frame_group (crc_group),
        .ext_mode    (ext_mode),
        .table_flat  (table_flat),
        .result      (look_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= crc_done;
            if (crc_done) begin
                res_q <= look_res;
            end else begin
                res_q.hit <= 1'b0;
            end
        end
    end

    assign match_valid = valid_q;
    assign match_hit   = res_q.hit;
    assign match_index = res_q.index;

endmodule

// File: rtl/dahf_checker.sv
module dahf_checker
    import dahf_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       ext_mode,
    input logic                       reg_wr,
    input logic [REG_AW-1:0]          reg_addr,
    input logic [WORD_W-1:0]          reg_wdata,
    input logic                       lookup_req,
    input logic                       frame_group,
    input logic [NUM_REGS*WORD_W-1:0] table_flat,
    input logic                       match_valid,
    input logic                       match_hit,
    input logic [EXT_IDX_W-1:0]       match_index
);
    logic              sh_wr;
    logic [REG_AW-1:0] sh_addr;
    logic [WORD_W-1:0] sh_data;
    logic [WORD_W-1:0] sh_word;

    always_ff @(posedge clk) begin
        sh_wr   <= rst ? 1'b0 : reg_wr;
        sh_addr <= reg_addr;
        sh_data <= reg_wdata;
    end

    always_comb sh_word = table_flat[int'(sh_addr)*WORD_W +: WORD_W];

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (table_flat == '0) && !match_valid && !match_hit);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        sh_wr |-> (sh_word == sh_data));

    assert_result_follows_R4: assert property (@(posedge clk) disable iff (rst)
        lookup_req |=> match_valid);

    assert_result_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> $past(lookup_req));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        match_valid |=> !match_valid);

    assert_split_index_range_R5: assert property (@(posedge clk) disable iff (rst)
        (match_valid && !$past(ext_mode)) |-> (match_index < EXT_IDX_W'(256)));

    assert_ext_unicast_miss_R7: assert property (@(posedge clk) disable iff (rst)
        (match_valid && $past(ext_mode) && !$past(frame_group)) |-> !match_hit);

    assert_idle_no_hit_R12: assert property (@(posedge clk) disable iff (rst)
        !match_valid |-> !match_hit);

endmodule

bind da_hash_filter dahf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_mode    (ext_mode),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .lookup_req  (crc_done),
    .frame_group (crc_group),
    .table_flat  (table_flat),
    .match_valid (match_valid),
    .match_hit   (match_hit),
    .match_index (match_index)
);

// File: tb/da_hash_filter_tb.sv
module da_hash_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_mode = 1'b0;
    logic        byte_valid = 1'b0;
    logic        byte_first = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        match_valid;
    logic        match_hit;
    logic [8:0]  match_index;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #2 clk = ~clk;   // 250 MHz

    da_hash_filter u_dut (
        .clk         (clk),
        .rst         (rst),
        .ext_mode    (ext_mode),
        .byte_valid  (byte_valid),
        .byte_first  (byte_first),
        .byte_data   (byte_data),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .match_valid (match_valid),
        .match_hit   (match_hit),
        .match_index (match_index)
    );

    always @(posedge clk) if (!rst && match_valid) pulses++;

    // ---------------- reference model from the requirements ----------------
    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            b = a[47 - 8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ b[i];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        return c;
    endfunction

    function automatic logic [8:0] ref_index(input logic [47:0] a, input bit ext);
        logic [31:0] c;
        c = ref_crc(a);
        return ext ? c[31:23] : {1'b0, c[31:24]};
    endfunction

    function automatic logic [3:0] ref_reg(input logic [47:0] a, input bit ext);
        logic [8:0] ix;
        ix = ref_index(a, ext);
        return ext ? ix[8:5] : {a[40], ix[7:5]};
    endfunction

    function automatic logic [31:0] ref_bit(input logic [47:0] a, input bit ext);
        logic [8:0] ix;
        ix = ref_index(a, ext);
        return 32'h8000_0000 >> ix[4:0];
    endfunction

    // ---------------- helpers ----------------
    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_table();
        for (int r = 0; r < 16; r++) wr_word(4'(r), 32'h0);
    endtask

    task automatic set_mode(input bit m);
        @(negedge clk);
        ext_mode = m;
    endtask

    task automatic drive_bytes(input logic [47:0] a, input int n, input bit with_first);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_first = with_first && (k == 0);
            byte_data  = a[47 - 8*k -: 8];
        end
        @(negedge clk);
        byte_valid = 1'b0;
        byte_first = 1'b0;
    endtask

    task automatic do_lookup(input logic [47:0] a, input bit wr_now,
                             input logic [3:0] wa, input logic [31:0] wd,
                             output logic hit, output logic [8:0] idx,
                             output logic v_early, output logic v,
                             output logic v_late, output logic h_late);
        drive_bytes(a, 6, 1'b1);      // now just after edge E
        v_early = match_valid;
        if (wr_now) begin
            reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd;
        end
        @(negedge clk);               // just after edge E+1
        reg_wr = 1'b0;
        v   = match_valid;
        hit = match_hit;
        idx = match_index;
        @(negedge clk);
        v_late = match_valid;
        h_late = match_hit;
    endtask

    task automatic expect_lookup(input string req, input logic [47:0] a,
                                 input bit ext, input logic exp_hit);
        logic h, ve, v, vl, hl;
        logic [8:0] ix;
        do_lookup(a, 1'b0, 4'h0, 32'h0, h, ix, ve, v, vl, hl);
        expect_eq("R4", "valid before result edge", 32'(ve), 0);
        expect_eq("R4", "valid pulse", 32'(v), 1);
        expect_eq("R4", "valid width", 32'(vl), 0);
        expect_eq("R12", "hit after pulse", 32'(hl), 0);
        expect_eq(req, "index", 32'(ix), 32'(ref_index(a, ext)));
        expect_eq(req, "hit", 32'(h), 32'(exp_hit));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] d;
        expect_eq("R1", "valid after reset", 32'(match_valid), 0);
        expect_eq("R1", "hit after reset", 32'(match_hit), 0);
        for (int r = 0; r < 16; r++) begin
            rd_word(4'(r), d);
            expect_eq("R1", "word after reset", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] d;
        for (int r = 0; r < 16; r++) wr_word(4'(r), 32'hA5C3_0000 | (32'(r) * 32'h0101));
        for (int r = 15; r >= 0; r--) begin
            rd_word(4'(r), d);
            expect_eq("R2", "readback", d, 32'hA5C3_0000 | (32'(r) * 32'h0101));
        end
        clear_table();
    endtask

    task automatic t_split_unicast();
        logic [47:0] a;
        logic [3:0]  r;
        logic [8:0]  ix;
        a  = 48'h00_1B_21_3C_4D_5E;
        r  = ref_reg(a, 1'b0);
        ix = ref_index(a, 1'b0);
        set_mode(1'b0);
        expect_lookup("R3", a, 1'b0, 1'b0);
        wr_word(r, 32'h1 << ix[4:0]);                 // mirrored bit only
        expect_lookup("R8", a, 1'b0, 1'b0);
        wr_word(r, ref_bit(a, 1'b0));
        expect_lookup("R8", a, 1'b0, 1'b1);
        wr_word(r, 32'h0);
        wr_word(r | 4'h8, ref_bit(a, 1'b0));           // same slot, wrong bank
        expect_lookup("R5", a, 1'b0, 1'b0);
        clear_table();
    endtask

    task automatic t_split_multicast();
        logic [47:0] a;
        logic [3:0]  r;
        a = 48'h01_00_5E_00_00_FB;
        r = ref_reg(a, 1'b0);
        set_mode(1'b0);
        expect_eq("R5", "group bank chosen", 32'(r[3]), 1);
        wr_word(r & 4'h7, ref_bit(a, 1'b0));           // individual bank only
        expect_lookup("R5", a, 1'b0, 1'b0);
        wr_word(r, ref_bit(a, 1'b0));
        expect_lookup("R5", a, 1'b0, 1'b1);
        clear_table();
    endtask

    task automatic t_ext_multicast();
        logic [47:0] lo_a, hi_a, c;
        bit got_lo, got_hi;
        got_lo = 1'b0; got_hi = 1'b0; lo_a = '0; hi_a = '0;
        for (int k = 0; k < 64; k++) begin
            c = 48'h01_00_5E_00_00_00 | 48'(k);
            if (ref_index(c, 1'b1) < 9'd256 && !got_lo) begin lo_a = c; got_lo = 1'b1; end
            if (ref_index(c, 1'b1) >= 9'd256 && !got_hi) begin hi_a = c; got_hi = 1'b1; end
        end
        expect_eq("R6", "low-half address found", 32'(got_lo), 1);
        expect_eq("R6", "high-half address found", 32'(got_hi), 1);
        set_mode(1'b1);
        wr_word(ref_reg(lo_a, 1'b1) ^ 4'h8, ref_bit(lo_a, 1'b1));
        expect_lookup("R6", lo_a, 1'b1, 1'b0);
        wr_word(ref_reg(lo_a, 1'b1), ref_bit(lo_a, 1'b1));
        expect_lookup("R6", lo_a, 1'b1, 1'b1);
        clear_table();
        wr_word(ref_reg(hi_a, 1'b1) ^ 4'h8, ref_bit(hi_a, 1'b1));
        expect_lookup("R6", hi_a, 1'b1, 1'b0);
        wr_word(ref_reg(hi_a, 1'b1), ref_bit(hi_a, 1'b1));
        expect_lookup("R6", hi_a, 1'b1, 1'b1);
        clear_table();
    endtask

    task automatic t_ext_unicast();
        logic [47:0] a;
        a = 48'h02_44_66_88_AA_CC;
        set_mode(1'b1);
        for (int r = 0; r < 16; r++) wr_word(4'(r), 32'hFFFF_FFFF);
        expect_lookup("R7", a, 1'b1, 1'b0);
        clear_table();
        set_mode(1'b0);
    endtask

    task automatic t_abort();
        logic [47:0] a, b;
        int p0;
        a = 48'h00_11_22_33_44_55;
        b = 48'h01_80_C2_00_00_0E;
        set_mode(1'b0);
        wr_word(ref_reg(b, 1'b0), ref_bit(b, 1'b0));
        p0 = pulses;
        drive_bytes(a, 4, 1'b1);
        expect_lookup("R9", b, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        expect_eq("R9", "pulse count", 32'(pulses - p0), 1);
        clear_table();
    endtask

    task automatic t_stray();
        logic [47:0] a;
        int p0;
        a = 48'h01_00_5E_7F_FF_FA;
        set_mode(1'b0);
        p0 = pulses;
        drive_bytes(a, 6, 1'b0);
        repeat (3) @(negedge clk);
        expect_eq("R10", "pulses from stray bytes", 32'(pulses - p0), 0);
        expect_lookup("R10", a, 1'b0, 1'b0);
        p0 = pulses;
        drive_bytes(a, 8, 1'b0);
        repeat (3) @(negedge clk);
        expect_eq("R10", "pulses after completed address", 32'(pulses - p0), 0);
    endtask

    task automatic t_collision();
        logic [47:0] a;
        logic [3:0]  r;
        logic [31:0] w, d;
        logic h, ve, v, vl, hl;
        logic [8:0] ix;
        a = 48'h00_AA_BB_CC_DD_EE;
        r = ref_reg(a, 1'b0);
        w = ref_bit(a, 1'b0);
        set_mode(1'b0);
        do_lookup(a, 1'b1, r, w, h, ix, ve, v, vl, hl);
        expect_eq("R11", "valid with write", 32'(v), 1);
        expect_eq("R11", "hit uses old word (set)", 32'(h), 0);
        rd_word(r, d);
        expect_eq("R11", "write landed", d, w);
        expect_lookup("R11", a, 1'b0, 1'b1);
        do_lookup(a, 1'b1, r, 32'h0, h, ix, ve, v, vl, hl);
        expect_eq("R11", "hit uses old word (clear)", 32'(h), 1);
        expect_lookup("R11", a, 1'b0, 1'b0);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_split_unicast();
        t_split_multicast();
        t_ext_multicast();
        t_ext_unicast();
        t_abort();
        t_stray();
        t_collision();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule